// File: doc/BRIEF.md
# Shared Low-Frequency Clock Source Arbiter

This block owns the choice of physical source for one low-frequency clock that several independent requesters share. Each requester has its own small control port: a source select, start and stop strobes, a calibrate strobe, a completion pulse and a status readback. The block keeps one latched request per port. From the live requests it picks the most accurate source, and it drives the enable lines of three shared sources: an RC oscillator, a crystal oscillator and a synthesized source. Each source returns a ready flag.

A change of selection is make-before-break. The block enables the new source, keeps the old one selected until the new source reports ready, and then drops any source that no live request still needs. RC calibration can be requested from any port. A single measurement runs, and its completion is announced on every port. Each port's status shows only what that port asked for. The actual selection is brought out on a separate debug output.

Top module: `lfclk_arbiter`

## Requirements
- R1: A start strobe on a port latches that port's source select (0 = none, 1 = RC, 2 = crystal, 3 = synthesized) and sets the port's run flag when the select is non-zero. A stop strobe clears the run flag. If both strobes arrive together, the stop wins. Both take effect at the next clock edge.
- R2: The status outputs of a port show the source and run flag latched through that port only, whatever other ports request and whatever source is selected.
- R3: The target source is the most accurate source among ports whose run flag is set. Accuracy ranks crystal highest, then synthesized, then RC.
- R4: When the port holding the most accurate request stops while another port still runs a less accurate source, the selection moves to that less accurate source and does not stop.
- R5: While the target differs from the selected source, both are enabled. The selected source changes only at the clock edge after the target's ready flag is seen high. A target of none is taken at once.
- R6: A source's enable is high only while it is selected, while it is the target, or (RC only) while a calibration is in progress. Any other source is turned off after the switchover.
- R7: When no port runs, the selection becomes none and the running flag falls.
- R8: A calibrate strobe from any port starts a calibration when none is in progress. The RC enable is raised, and the measurement start pulse is given for one cycle in the first cycle that RC reports ready.
- R9: When the measurement reports done, every port receives a one-cycle completion pulse at the next clock edge, whichever port triggered it.
- R10: Calibrate strobes that arrive while a calibration is in progress merge into it and do not cause a second measurement start.
- R11: The debug output shows the selected source code, and the running flag is high exactly when that code is not none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start_i | input | N_PORTS | Per-port start strobe |
| req_stop_i | input | N_PORTS | Per-port stop strobe |
| req_cal_i | input | N_PORTS | Per-port calibrate strobe |
| req_src_i | input | 2*N_PORTS | Per-port source select, 2 bits per port |
| req_done_o | output | N_PORTS | Per-port calibration completion pulse |
| stat_src_o | output | 2*N_PORTS | Per-port latched source |
| stat_run_o | output | N_PORTS | Per-port run flag |
| rc_en_o | output | 1 | RC oscillator enable |
| rc_rdy_i | input | 1 | RC oscillator ready |
| xo_en_o | output | 1 | Crystal oscillator enable |
| xo_rdy_i | input | 1 | Crystal oscillator ready |
| syn_en_o | output | 1 | Synthesized source enable |
| syn_rdy_i | input | 1 | Synthesized source ready |
| cal_start_o | output | 1 | Calibration measurement start pulse |
| cal_done_i | input | 1 | Calibration measurement done |
| sel_src_o | output | 2 | Debug: selected source code |
| sel_run_o | output | 1 | Debug: selected clock running |

## Verification
The bench builds the block with N_PORTS = 2, which is the sharing case where one port's request can override or back up the other's. Its oscillator models have different start-up delays (RC 2, synthesized 3, crystal 6 cycles). Because of this, every switchover spends several cycles with two sources enabled, and the make-before-break window and the fallback can be observed. A calibration measurement takes three cycles, which leaves room to land a second port's calibrate strobe inside a running calibration and to test the merge.

// File: rtl/lfarb_pkg.sv
package lfarb_pkg;

    localparam int SRC_W   = 2;
    localparam int NUM_SRC = 4;

    localparam logic [SRC_W-1:0] SRC_NONE  = 2'd0;
    localparam logic [SRC_W-1:0] SRC_RC    = 2'd1;
    localparam logic [SRC_W-1:0] SRC_XTAL  = 2'd2;
    localparam logic [SRC_W-1:0] SRC_SYNTH = 2'd3;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             run;
    } req_t;

    typedef enum logic [1:0] {
        CAL_IDLE    = 2'd0,
        CAL_WAIT_RC = 2'd1,
        CAL_MEAS    = 2'd2
    } cal_st_e;

    // Accuracy rank: larger is better.
    function automatic logic [1:0] src_rank(input logic [SRC_W-1:0] s);
        case (s)
            SRC_RC:    return 2'd1;
            SRC_SYNTH: return 2'd2;
            SRC_XTAL:  return 2'd3;
            default:   return 2'd0;
        endcase
    endfunction

    function automatic logic [SRC_W-1:0] better_src(input logic [SRC_W-1:0] a,
                                                    input logic [SRC_W-1:0] b);
        return (src_rank(b) > src_rank(a)) ? b : a;
    endfunction

endpackage

// File: rtl/lfarb_req.sv
module lfarb_req
    import lfarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [SRC_W-1:0] sel_i,
    output req_t             req_o
);

    req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (stop_i) begin
            req_q.run <= 1'b0;
        end else if (start_i) begin
            req_q.src <= sel_i;
            req_q.run <= (sel_i != SRC_NONE);
        end
    end

    assign req_o = req_q;

    p_stop_clears_r1: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !req_q.run);

    p_start_latches_r1: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stop_i) |=> (req_q.src == $past(sel_i)));

endmodule

// File: rtl/lfarb_select.sv
module lfarb_select
    import lfarb_pkg::*;
#(
    parameter int N_PORTS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  req_t [N_PORTS-1:0]    reqs_i,
    input  logic [NUM_SRC-1:0]    rdy_i,
    input  logic                  cal_rc_i,
    output logic [NUM_SRC-1:0]    en_o,
    output logic [SRC_W-1:0]      cur_o
);

    logic [SRC_W-1:0] target;
    logic [SRC_W-1:0] cur_q;
    logic [NUM_SRC-1:0] rdy_d;

    always_comb begin
        target = SRC_NONE;
        for (int p = 0; p < N_PORTS; p++) begin
            if (reqs_i[p].run) target = better_src(target, reqs_i[p].src);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= SRC_NONE;
            rdy_d <= '0;
        end else begin
            rdy_d <= rdy_i;
            if (target != cur_q && (target == SRC_NONE || rdy_i[target]))
                cur_q <= target;
        end
    end

    assign en_o[0] = 1'b0;
    for (genvar s = 1; s < NUM_SRC; s++) begin : g_en
        localparam logic [SRC_W-1:0] CODE = SRC_W'(s);
        localparam bit IS_RC = (s == 1);
        assign en_o[s] = (cur_q == CODE) || (target == CODE) || (IS_RC && cal_rc_i);
    end

    assign cur_o = cur_q;

    p_switch_after_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q) && cur_q != SRC_NONE) |-> rdy_d[cur_q]);

    p_selected_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q != SRC_NONE) |-> en_o[cur_q]);

endmodule

// File: rtl/lfarb_cal.sv
module lfarb_cal
    import lfarb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic rc_rdy_i,
    input  logic meas_done_i,
    output logic rc_need_o,
    output logic meas_start_o,
    output logic done_o
);

    cal_st_e st_q;
    logic    done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CAL_IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                CAL_IDLE:    if (trig_i) st_q <= CAL_WAIT_RC;
                CAL_WAIT_RC: if (rc_rdy_i) st_q <= CAL_MEAS;
                CAL_MEAS: if (meas_done_i) begin
                    st_q   <= CAL_IDLE;
                    done_q <= 1'b1;
                end
                default:     st_q <= CAL_IDLE;
            endcase
        end
    end

    assign rc_need_o    = (st_q != CAL_IDLE);
    assign meas_start_o = (st_q == CAL_WAIT_RC) && rc_rdy_i;
    assign done_o       = done_q;

    p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
        meas_start_o |=> !meas_start_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_start_needs_rc_r8: assert property (@(posedge clk) disable iff (rst)
        meas_start_o |-> (rc_rdy_i && rc_need_o));

endmodule

// File: rtl/lfclk_arbiter.sv
module lfclk_arbiter
    import lfarb_pkg::*;
#(
    parameter int N_PORTS = 2,
    localparam int SRCV_W = SRC_W * N_PORTS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PORTS-1:0] req_start_i,
    input  logic [N_PORTS-1:0] req_stop_i,
    input  logic [N_PORTS-1:0] req_cal_i,
    input  logic [SRCV_W-1:0]  req_src_i,
    output logic [N_PORTS-1:0] req_done_o,
    output logic [SRCV_W-1:0]  stat_src_o,
    output logic [N_PORTS-1:0] stat_run_o,
    output logic               rc_en_o,
    input  logic               rc_rdy_i,
    output logic               xo_en_o,
    input  logic               xo_rdy_i,
    output logic               syn_en_o,
    input  logic               syn_rdy_i,
    output logic               cal_start_o,
    input  logic               cal_done_i,
    output logic [SRC_W-1:0]   sel_src_o,
    output logic               sel_run_o
);

    req_t [N_PORTS-1:0] reqs;
    logic [NUM_SRC-1:0] rdy_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic               cal_rc;
    logic               cal_done_pulse;
    logic [SRC_W-1:0]   cur;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        lfarb_req u_req (
            .clk     (clk),
            .rst     (rst),
            .start_i (req_start_i[p]),
            .stop_i  (req_stop_i[p]),
            .sel_i   (req_src_i[SRC_W*p +: SRC_W]),
            .req_o   (reqs[p])
        );
        assign stat_src_o[SRC_W*p +: SRC_W] = reqs[p].src;
        assign stat_run_o[p]                = reqs[p].run;
    end

    assign rdy_vec = {syn_rdy_i, xo_rdy_i, rc_rdy_i, 1'b1};

    lfarb_select #(.N_PORTS(N_PORTS)) u_select (
        .clk      (clk),
        .rst      (rst),
        .reqs_i   (reqs),
        .rdy_i    (rdy_vec),
        .cal_rc_i (cal_rc),
        .en_o     (en_vec),
        .cur_o    (cur)
    );

    lfarb_cal u_cal (
        .clk          (clk),
        .rst          (rst),
        .trig_i       (|req_cal_i),
        .rc_rdy_i     (rc_rdy_i),
        .meas_done_i  (cal_done_i),
        .rc_need_o    (cal_rc),
        .meas_start_o (cal_start_o),
        .done_o       (cal_done_pulse)
    );

    assign rc_en_o    = en_vec[SRC_RC];
    assign xo_en_o    = en_vec[SRC_XTAL];
    assign syn_en_o   = en_vec[SRC_SYNTH];
    assign req_done_o = {N_PORTS{cal_done_pulse}};
    assign sel_src_o  = cur;
    assign sel_run_o  = (cur != SRC_NONE);

    p_done_all_ports_r9: assert property (@(posedge clk) disable iff (rst)
        (|req_done_o) |-> (&req_done_o));

    p_run_flag_r11: assert property (@(posedge clk) disable iff (rst)
        sel_run_o == (sel_src_o != SRC_NONE));

endmodule

// File: tb/lfclk_arbiter_bench.sv
`timescale 1ns/1ps
module lfclk_arbiter_bench;

    localparam int NP = 2;
    localparam int DLY_RC = 2, DLY_XO = 6, DLY_SYN = 3, MEAS_CYC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NP-1:0]   start = '0, stop = '0, cal = '0;
    logic [2*NP-1:0] srcsel = '0;
    logic [NP-1:0]   done_o, stat_run;
    logic [2*NP-1:0] stat_src;
    logic rc_en, xo_en, syn_en, rc_rdy, xo_rdy, syn_rdy;
    logic cal_start, cal_done;
    logic [1:0] sel_src;
    logic sel_run;

    lfclk_arbiter #(.N_PORTS(NP)) u_lfclk_arbiter (
        .clk(clk), .rst(rst),
        .req_start_i(start), .req_stop_i(stop), .req_cal_i(cal), .req_src_i(srcsel),
        .req_done_o(done_o), .stat_src_o(stat_src), .stat_run_o(stat_run),
        .rc_en_o(rc_en), .rc_rdy_i(rc_rdy), .xo_en_o(xo_en), .xo_rdy_i(xo_rdy),
        .syn_en_o(syn_en), .syn_rdy_i(syn_rdy),
        .cal_start_o(cal_start), .cal_done_i(cal_done),
        .sel_src_o(sel_src), .sel_run_o(sel_run)
    );

    // Oscillator and measurement environment
    int c_rc = 0, c_xo = 0, c_syn = 0, c_meas = 0;
    always @(posedge clk) begin
        c_rc  <= rc_en  ? ((c_rc  < DLY_RC)  ? c_rc  + 1 : c_rc)  : 0;
        c_xo  <= xo_en  ? ((c_xo  < DLY_XO)  ? c_xo  + 1 : c_xo)  : 0;
        c_syn <= syn_en ? ((c_syn < DLY_SYN) ? c_syn + 1 : c_syn) : 0;
        if (rst) c_meas <= 0;
        else if (cal_start) c_meas <= MEAS_CYC;
        else if (c_meas > 0) c_meas <= c_meas - 1;
    end
    assign rc_rdy   = rc_en  && (c_rc  == DLY_RC);
    assign xo_rdy   = xo_en  && (c_xo  == DLY_XO);
    assign syn_rdy  = syn_en && (c_syn == DLY_SYN);
    assign cal_done = (c_meas == 1);

    // Behavioural reference model
    int m_src [NP];
    int m_run [NP];
    int m_cur = 0, m_cal = 0, m_done = 0;

    function automatic int rank(int s);
        case (s) 1: return 1; 3: return 2; 2: return 3; default: return 0; endcase
    endfunction

    function automatic int m_target();
        int t = 0;
        for (int p = 0; p < NP; p++)
            if (m_run[p] != 0 && rank(m_src[p]) > rank(t)) t = m_src[p];
        return t;
    endfunction

    function automatic bit rdy_of(int s);
        case (s) 1: return rc_rdy; 2: return xo_rdy; 3: return syn_rdy; default: return 1'b1; endcase
    endfunction

    initial for (int p = 0; p < NP; p++) begin m_src[p] = 0; m_run[p] = 0; end

    always @(posedge clk) begin
        int t;
        t = m_target();
        if (rst) begin
            for (int p = 0; p < NP; p++) begin m_src[p] <= 0; m_run[p] <= 0; end
            m_cur <= 0; m_cal <= 0; m_done <= 0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (stop[p]) m_run[p] <= 0;
                else if (start[p]) begin
                    m_src[p] <= int'(srcsel[2*p +: 2]);
                    m_run[p] <= (srcsel[2*p +: 2] != 2'd0) ? 1 : 0;
                end
            end
            if (t != m_cur && (t == 0 || rdy_of(t))) m_cur <= t;
            m_done <= 0;
            case (m_cal)
                0: if (|cal) m_cal <= 1;
                1: if (rc_rdy) m_cal <= 2;
                default: if (cal_done) begin m_cal <= 0; m_done <= 1; end
            endcase
        end
    end

    int n_checks = 0, n_fail = 0;
    bit started = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            int t;
            t = m_target();
            check(sel_src == 2'(m_cur), "R3/R4/R11 sel_src", int'(sel_src), m_cur);
            check(sel_run == (m_cur != 0), "R7/R11 sel_run", int'(sel_run), int'(m_cur != 0));
            check(rc_en == (m_cur == 1 || t == 1 || m_cal != 0), "R6/R8 rc_en", int'(rc_en),
                  int'(m_cur == 1 || t == 1 || m_cal != 0));
            check(xo_en == (m_cur == 2 || t == 2), "R5/R6 xo_en", int'(xo_en), int'(m_cur == 2 || t == 2));
            check(syn_en == (m_cur == 3 || t == 3), "R5/R6 syn_en", int'(syn_en), int'(m_cur == 3 || t == 3));
            check(cal_start == (m_cal == 1 && rc_rdy), "R8 cal_start", int'(cal_start),
                  int'(m_cal == 1 && rc_rdy));
            check(done_o == {NP{m_done[0]}}, "R9 done", int'(done_o), m_done * 3);
            for (int p = 0; p < NP; p++) begin
                check(stat_src[2*p +: 2] == 2'(m_src[p]), "R2 stat_src", int'(stat_src[2*p +: 2]), m_src[p]);
                check(stat_run[p] == (m_run[p] != 0), "R1/R2 stat_run", int'(stat_run[p]), m_run[p]);
            end
        end
    end

    int n_starts = 0, n_done1 = 0;
    always @(posedge clk) begin
        if (!rst && cal_start) n_starts++;
        if (!rst && done_o[1]) n_done1++;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(int p, int s);
        @(negedge clk);
        start[p] = 1'b1; srcsel[2*p +: 2] = 2'(s);
        @(negedge clk);
        start[p] = 1'b0;
    endtask

    task automatic do_stop(int p);
        @(negedge clk); stop[p] = 1'b1;
        @(negedge clk); stop[p] = 1'b0;
    endtask

    task automatic do_cal(int p);
        @(negedge clk); cal[p] = 1'b1;
        @(negedge clk); cal[p] = 1'b0;
    endtask

    bit finished = 1'b0;

    initial begin
        @(posedge clk); started = 1'b1;
        cyc(3);
        check(sel_src == 2'd0 && !rc_en && !xo_en && !syn_en && stat_run == '0,
              "R7 reset state", int'(sel_src), 0);
        rst = 1'b0;
        do_start(0, 1); cyc(6);                       // R1 R3: RC alone
        check(sel_src == 2'd1, "R3 RC selected", int'(sel_src), 1);
        do_start(1, 2); cyc(2);                       // R5: crystal pending
        check(sel_src == 2'd1 && xo_en && rc_en, "R5 old held while new warms", int'(sel_src), 1);
        cyc(8);
        check(sel_src == 2'd2 && !rc_en, "R6 RC released after switch", int'(rc_en), 0);
        check(stat_src[1:0] == 2'd1, "R2 port0 status own", int'(stat_src[1:0]), 1);
        do_start(0, 3); cyc(5);
        check(sel_src == 2'd2, "R3 crystal beats synth", int'(sel_src), 2);
        do_stop(1); cyc(8);                           // R4 fallback
        check(sel_src == 2'd3 && !xo_en, "R4 fallback to synth", int'(sel_src), 3);
        n_starts = 0; n_done1 = 0;
        do_cal(0); cyc(1); do_cal(1); cyc(12);        // R10 merge
        check(n_starts == 1, "R10 merged trigger", n_starts, 1);
        check(n_done1 == 1, "R9 done on other port", n_done1, 1);
        n_done1 = 0;
        do_cal(1); cyc(12);
        check(n_done1 == 1, "R8 cal from port1", n_done1, 1);
        @(negedge clk); start[0] = 1'b1; stop[0] = 1'b1; srcsel[1:0] = 2'd2;
        @(negedge clk); start = '0; stop = '0;       // R1 stop wins
        check(stat_run[0] == 1'b0, "R1 stop wins", int'(stat_run[0]), 0);
        cyc(4);
        check(sel_src == 2'd0 && !sel_run, "R7 all stopped", int'(sel_src), 0);
        do_start(1, 0); cyc(2);
        check(stat_run[1] == 1'b0, "R1 start with none", int'(stat_run[1]), 0);
        do_start(0, 2); do_start(1, 3); cyc(10);
        do_stop(0); cyc(2);
        do_start(0, 1); cyc(10);
        @(negedge clk); stop = '1;
        @(negedge clk); stop = '0;
        cyc(4);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule